// File: doc/BRIEF.md
# Crosswise Column Binary Multiplier

This block multiplies two unsigned 14-bit integers with no clock and no state, and returns a 27-bit result. It sits between a decimal-to-binary front end and a binary-to-decimal back end. Each operand arriving from the front end is a four-digit decimal value, so neither operand exceeds 9999. The largest possible result is therefore 99980001, which needs 27 bits.

Every single-bit partial product `mcand[i] & mplier[j]` is placed in column `i+j`. A column's bits are its own AND terms plus every carry that the column below it emits. Each column is folded to one result bit by a small tree of full and half adders. Every adder in a column sends its carry one column up. The carries out of the topmost kept column are discarded on purpose, so a 28th bit never exists. The block has no handshake and no valid or ready pins. The output follows the inputs combinationally. A surrounding pipeline registers the result wherever its timing needs it.

Top module: `crosswise_mul`

## Requirements
- R1: For every pair of operands that are both 9999 or less, `product` equals the exact arithmetic product of `mcand` and `mplier`.
- R2: The largest in-range pair (9999 × 9999) gives 99980001 (hex 5F592E1), which sets the top output bit 26. No in-range pair gives a result above that value.
- R3: When either operand is zero, `product` is zero, including straight after power-up with both inputs at zero.
- R4: When one operand is 1, `product` equals the other operand, zero-extended to 27 bits.
- R5: Swapping the two operands leaves `product` unchanged.
- R6: When one operand is a power of two 2^n (n from 0 to 13), `product` equals the other operand shifted left by n places.
- R7: When an operand is above 9999, `product` is the true product reduced modulo 2^27. For example, 16383 × 16383 gives 134184961 (hex 7FF8001).
- R8: The block holds no state. A new operand pair applied in every cycle gives its own correct product within that same cycle, with no dependence on earlier pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 14 | First unsigned operand (multiplicand) |
| mplier | input | 14 | Second unsigned operand (multiplier) |
| product | output | 27 | Unsigned product, lower 27 bits |

## Verification
The hardest cases are the middle columns, where up to fourteen AND terms meet a long run of incoming carries. The other hard case is the discarded top carry, which only becomes visible when the true product reaches bit 27. Random decimal-range operands rarely stress either case, so the stimulus applies these directly:
- all-ones and near-all-ones operands (9999, 16383), which fill the middle columns;
- out-of-range pairs, whose products cross 2^27, so that the wrap is observed;
- a walking power of two against a fixed operand, which pushes a single shifted copy through every column;
- consecutive cycles alternating full-scale and zero operands, which show that no earlier result lingers.

// File: rtl/cw_mul_pkg.sv
package cw_mul_pkg;

  // Lowest multiplicand index contributing to column k.
  function automatic int pp_lo(input int k, input int w);
    return (k > w - 1) ? k - (w - 1) : 0;
  endfunction

  // Number of AND terms landing in column k.
  function automatic int pp_cnt(input int k, input int w);
    int hi;
    if (k > 2 * w - 2) return 0;
    hi = (k < w - 1) ? k : w - 1;
    return hi - pp_lo(k, w) + 1;
  endfunction

  // Bits entering column k: its AND terms plus carries from column k-1.
  // A column of m bits emits floor(m/2) carries.
  function automatic int col_bits(input int k, input int w);
    int m;
    int c;
    m = 0;
    c = 0;
    for (int i = 0; i <= k; i++) begin
      m = pp_cnt(i, w) + c;
      c = m / 2;
    end
    return m;
  endfunction

  function automatic int col_cin(input int k, input int w);
    return (k == 0) ? 0 : col_bits(k - 1, w) / 2;
  endfunction

  // Offset of column k's carry outputs on the shared carry bus.
  function automatic int carry_ofs(input int k, input int w);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += col_bits(i, w) / 2;
    return s;
  endfunction

endpackage

// File: rtl/cw_full_add.sv
module cw_full_add (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (z & (x ^ y));
endmodule

// File: rtl/cw_half_add.sv
module cw_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y;
  assign co = x & y;
endmodule

// File: rtl/cw_col_sum.sv
// Folds N same-weight bits to one sum bit. Full adders take operands from
// the front of a pool and append their sums at its back, which yields a
// balanced tree; a final half adder handles an even leftover pair.
module cw_col_sum #(
  parameter int N = 3
) (
  input  logic [N-1:0]   bits,
  output logic           sum,
  output logic [N/2-1:0] carries
);
  localparam int NFA = (N - 1) / 2;
  localparam int NHA = (N - 1) % 2;

  logic [N+NFA-1:0] pool;
  assign pool[N-1:0] = bits;

  for (genvar t = 0; t < NFA; t++) begin : g_fa
    cw_full_add u_fa (
      .x (pool[3*t]),
      .y (pool[3*t+1]),
      .z (pool[3*t+2]),
      .s (pool[N+t]),
      .co(carries[t])
    );
  end

  if (NHA == 1) begin : g_ha
    cw_half_add u_ha (
      .x (pool[3*NFA]),
      .y (pool[3*NFA+1]),
      .s (sum),
      .co(carries[NFA])
    );
  end else begin : g_pass
    assign sum = pool[3*NFA];
  end
endmodule

// File: rtl/crosswise_mul.sv
module crosswise_mul
  import cw_mul_pkg::*;
#(
  parameter int OPW = 14,
  parameter int PRW = 27
) (
  input  logic [OPW-1:0] mcand,
  input  logic [OPW-1:0] mplier,
  output logic [PRW-1:0] product
);
  localparam int NCOL  = PRW;
  localparam int CBW   = carry_ofs(NCOL - 1, OPW);
  localparam int CBW_S = (CBW > 0) ? CBW : 1;

  // Carries travelling from each kept column to the next.
  logic [CBW_S-1:0] cbus;

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    localparam int NP  = pp_cnt(k, OPW);
    localparam int NC  = col_cin(k, OPW);
    localparam int NM  = NP + NC;
    localparam int NCO = NM / 2;
    localparam int LO  = pp_lo(k, OPW);
    localparam int IOF = (k > 0) ? carry_ofs(k - 1, OPW) : 0;
    localparam int OOF = carry_ofs(k, OPW);

    if (NM == 0) begin : g_empty
      assign product[k] = 1'b0;
    end else begin : g_live
      logic [NM-1:0] in_bits;

      for (genvar t = 0; t < NP; t++) begin : g_and
        assign in_bits[t] = mcand[LO+t] & mplier[k-LO-t];
      end
      if (NC > 0) begin : g_cin
        assign in_bits[NM-1:NP] = cbus[IOF +: NC];
      end

      if (NM == 1) begin : g_single
        assign product[k] = in_bits[0];
      end else if (k < NCOL - 1) begin : g_sum
        cw_col_sum #(.N(NM)) u_sum (
          .bits   (in_bits),
          .sum    (product[k]),
          .carries(cbus[OOF +: NCO])
        );
      end else begin : g_top
        // Carries above the kept width are dropped by design.
        logic [NCO-1:0] spill_unused;
        cw_col_sum #(.N(NM)) u_sum (
          .bits   (in_bits),
          .sum    (product[k]),
          .carries(spill_unused)
        );
      end
    end
  end
endmodule

// File: rtl/cw_mul_chk.sv
module cw_mul_chk #(
  parameter int OPW   = 14,
  parameter int PRW   = 27,
  parameter int LIMIT = 9999
) (
  input logic [OPW-1:0] mcand,
  input logic [OPW-1:0] mplier,
  input logic [PRW-1:0] product
);
  localparam logic [OPW-1:0] LIM  = OPW'(LIMIT);
  localparam logic [PRW-1:0] CEIL = PRW'(LIMIT * LIMIT);

  logic [2*OPW-1:0] full;
  assign full = {{OPW{1'b0}}, mcand} * {{OPW{1'b0}}, mplier};

  always_comb begin
    if (!$isunknown({mcand, mplier})) begin
      AST_WRAP_MODULO: assert (product == PRW'(full)); // R7
      if (mcand <= LIM && mplier <= LIM) begin
        AST_EXACT_PRODUCT: assert ((full >> PRW) == '0 && product == PRW'(full)); // R1
        AST_PRODUCT_CEILING: assert (product <= CEIL); // R2
      end
      if (mcand == '0 || mplier == '0) begin
        AST_ZERO_ANNIHILATES: assert (product == '0); // R3
      end
      if (mcand == OPW'(1)) begin
        AST_UNIT_IDENTITY: assert (product == {{(PRW-OPW){1'b0}}, mplier}); // R4
      end
    end
  end
endmodule

bind crosswise_mul cw_mul_chk #(.OPW(OPW), .PRW(PRW)) u_chk (
  .mcand  (mcand),
  .mplier (mplier),
  .product(product)
);

// File: tb/tb_crosswise_mul.sv
module tb_crosswise_mul;
  localparam int HALF = 10; // 20-unit period: 50 MHz with 1 ns units

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] a_in = '0;
  logic [13:0] b_in = '0;
  logic [26:0] prod;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [13:0] a;
    logic [13:0] b;
    logic [26:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  crosswise_mul dut (
    .mcand  (a_in),
    .mplier (b_in),
    .product(prod)
  );

  always #HALF clk = ~clk;

  function automatic logic [26:0] ref_mul(input logic [13:0] x, input logic [13:0] y);
    longint p;
    p = longint'(x) * longint'(y);
    return p[26:0];
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: applies a pair just after a rising edge and queues its expectation.
  task automatic drive(input logic [13:0] x, input logic [13:0] y,
                       input logic [26:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a_in = x;
    b_in = y;
    it.a = x;
    it.b = y;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares at the falling edge, half a cycle after the change.
  initial begin
    wait (!rst);
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (prod !== it.exp) begin
          errors++;
          $display("FAIL %s: a=%0d b=%0d product=%0d expected=%0d",
                   it.tag, it.a, it.b, prod, it.exp);
        end
      end
    end
  end

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8: watchdog expired, product=%0d expected=settled run", prod);
      summary();
      $finish;
    end
  end

  initial begin
    logic [13:0] x;
    logic [13:0] y;
    #5;
    checks++; // R3 state after power-up with zero inputs
    if (prod !== 27'd0) begin
      errors++;
      $display("FAIL R3: power-up product=%0d expected=0", prod);
    end
    rst = 1'b0;

    drive(14'd0, 14'd0, 27'd0, "R3");
    drive(14'd0, 14'd9999, 27'd0, "R3");
    drive(14'd16383, 14'd0, 27'd0, "R3");

    drive(14'd1, 14'd1, 27'd1, "R4");
    drive(14'd1, 14'd9999, 27'd9999, "R4");
    drive(14'd4321, 14'd1, 27'd4321, "R4");

    drive(14'd9999, 14'd9999, 27'd99980001, "R2");
    drive(14'd9998, 14'd9999, 27'd99970002, "R2");

    drive(14'd1456, 14'd1645, 27'd2395120, "R1");
    drive(14'd2354, 14'd6369, 27'd14992626, "R1");
    drive(14'd6002, 14'd5002, 27'd30022004, "R1");
    drive(14'd8191, 14'd8191, 27'd67092481, "R1");

    for (int n = 0; n < 14; n++) begin
      drive(14'(1 << n), 14'd7777, 27'(27'd7777 << n), "R6");
      drive(14'd9999, 14'(1 << n), 27'(27'd9999 << n), "R6");
    end

    drive(14'd16383, 14'd16383, 27'd134184961, "R7");
    drive(14'd16383, 14'd9999, 27'(64'd16383 * 64'd9999), "R7");
    for (int i = 0; i < 60; i++) begin
      x = 14'($urandom_range(10000, 16383));
      y = 14'($urandom_range(0, 16383));
      drive(x, y, ref_mul(x, y), "R7");
    end

    for (int i = 0; i < 20; i++) begin
      drive(14'd9999, 14'd9999, 27'd99980001, "R8");
      drive(14'd0, 14'd0, 27'd0, "R8");
      drive(14'd9999, 14'd1, 27'd9999, "R8");
    end

    for (int i = 0; i < 400; i++) begin
      x = 14'($urandom_range(0, 9999));
      y = 14'($urandom_range(0, 9999));
      drive(x, y, ref_mul(x, y), "R1");
      if (i % 4 == 0) drive(y, x, ref_mul(x, y), "R5");
    end

    repeat (3) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R8: pending=%0d expected=0", sb.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule